// File: doc/BRIEF.md
# Acquisition Sample FIFO

This block sits between an analog converter front end and a byte-wide host register port. Each accepted conversion becomes one 16-bit record that carries the 12-bit result and the 4-bit number of the channel that produced it. Records queue in arrival order until the host drains them two bytes at a time. Capture can be switched on and off, and the whole buffer can be emptied at once.

Status shows empty, half full and a sticky overflow. An interrupt level rises when the fill level enters the upper half, so the host can drain a block of records per interrupt. The converter side is a plain valid/data write port with no back-pressure. A sample that finds the buffer full is lost, and that loss is recorded.

Top module: `acq_sample_fifo`

## Requirements
- R1: After synchronous reset the buffer is empty and capture is off. Overflow and the interrupt are clear, so status (address 3) reads 0x01 and control (address 0) reads 0x00.
- R2: A record is {result[11:0], channel[3:0]}: channel in bits 3:0, result in bits 15:4. Address 4 returns record bits 7:0 and address 5 returns bits 15:8.
- R3: A write to control (address 0) turns capture on when the byte is nonzero and off when it is zero. Control reads back 1 or 0. A sample that arrives while capture is off is discarded.
- R4: Records come out in the order they were accepted.
- R5: Reading address 4 returns the oldest record's low byte and latches its high byte without removing the record. Reading address 5 returns the latched high byte and removes the oldest record. Reading address 5 while the buffer is empty removes nothing.
- R6: Status bit 0 is set exactly when the buffer holds no record.
- R7: Status bit 1 is set exactly when the buffer holds at least DEPTH/2 records.
- R8: A sample that arrives with capture on and the buffer full is dropped and sets status bit 2. The bit stays set through reads and later samples.
- R9: A write of any value to address 2 empties the buffer and clears status bit 2. In that cycle it overrides any arriving sample and any removal.
- R10: The interrupt output rises in the cycle after the fill level moves from below DEPTH/2 to DEPTH/2 or more. It stays high until a write to address 1, and a new entry into half full wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Converter sample strobe |
| smp_chan | input | 4 | Channel number of the sample |
| smp_res | input | 12 | Conversion result |
| reg_addr | input | 3 | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write byte |
| reg_rd | input | 1 | Host read strobe (advances read side effects) |
| reg_rdata | output | 8 | Read byte for reg_addr, valid in the same cycle |
| irq | output | 1 | Half-full interrupt level |

## Verification
The bench builds the block with DEPTH set to 16, so the half-full threshold is 8 records. With that depth the buffer can be filled past full and drained many times within a few thousand cycles. This reaches the entry into half full, full-buffer drops, sticky overflow across reads, and flushes at any fill level. It also covers clears that land in the same cycle as a new half-full entry, which a 1024-record buffer would make rare.

// File: rtl/acq_fifo_pkg.sv
`timescale 1ns/1ps
package acq_fifo_pkg;
  localparam int CHAN_W = 4;
  localparam int RES_W  = 12;
  localparam int REC_W  = CHAN_W + RES_W;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_ICLR  = 3'd1,
    RA_FLUSH = 3'd2,
    RA_STAT  = 3'd3,
    RA_DLO   = 3'd4,
    RA_DHI   = 3'd5
  } reg_addr_e;

  function automatic logic [REC_W-1:0] pack_record(input logic [CHAN_W-1:0] ch,
                                                   input logic [RES_W-1:0] res);
    return {res, ch};
  endfunction

  function automatic logic at_half(input int unsigned cnt, input int unsigned depth);
    return cnt >= (depth / 2);
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic empty, input logic half,
                                                    input logic ovf);
    return {5'b0, ovf, half, empty};
  endfunction
endpackage

// File: rtl/acq_fifo_store.sv
`timescale 1ns/1ps
module acq_fifo_store
  import acq_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             pop_i,
  output logic [REC_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_o,
  output logic             half_enter_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [REC_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, cnt_nxt;
  logic             do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_CNT);
  assign half_o  = at_half(32'(count), DEPTH);
  assign head_o  = mem[rd_ptr];

  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_comb begin
    if (flush_i) cnt_nxt = '0;
    else         cnt_nxt = count + CW'(do_push) - CW'(do_pop);
  end

  assign half_enter_o = !half_o && at_half(32'(cnt_nxt), DEPTH);

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= rec_i;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);                                               // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full_o && !pop_i && !flush_i) |=> full_o);                        // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> empty_o);                                              // R9
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !empty_o && !push_i && !flush_i) |=> (count == $past(count) - CW'(1))); // R5
endmodule

// File: rtl/acq_fifo_flags.sv
`timescale 1ns/1ps
module acq_fifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  input  logic iclr_i,
  input  logic sample_req_i,
  input  logic full_i,
  input  logic half_enter_i,
  output logic ovf_o,
  output logic irq_o
);
  logic drop;
  assign drop = sample_req_i && full_i && !flush_i;

  always_ff @(posedge clk) begin
    if (rst)          ovf_o <= 1'b0;
    else if (flush_i) ovf_o <= 1'b0;
    else if (drop)    ovf_o <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               irq_o <= 1'b0;
    else if (half_enter_i) irq_o <= 1'b1;
    else if (iclr_i)       irq_o <= 1'b0;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !flush_i) |=> ovf_o);                                    // R8
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !ovf_o);                                               // R9
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !iclr_i) |=> irq_o);                                     // R10
endmodule

// File: rtl/acq_host_regs.sv
`timescale 1ns/1ps
module acq_host_regs
  import acq_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [REC_W-1:0]  head_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              enable_o,
  output logic              flush_o,
  output logic              iclr_o,
  output logic              pop_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [REC_W-BYTE_W-1:0] hold_hi;
  logic                    lo_rd;

  assign flush_o = reg_wr && (reg_addr == RA_FLUSH);
  assign iclr_o  = reg_wr && (reg_addr == RA_ICLR);
  assign lo_rd   = reg_rd && (reg_addr == RA_DLO);
  assign pop_o   = reg_rd && (reg_addr == RA_DHI);

  always_ff @(posedge clk) begin
    if (rst) enable_o <= 1'b0;
    else if (reg_wr && (reg_addr == RA_CTRL)) enable_o <= (reg_wdata != '0);
  end

  always_ff @(posedge clk) begin
    if (rst)        hold_hi <= '0;
    else if (lo_rd) hold_hi <= head_i[REC_W-1:BYTE_W];
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      RA_CTRL: rdata_o = {{(BYTE_W-1){1'b0}}, enable_o};
      RA_STAT: rdata_o = status_i;
      RA_DLO:  rdata_o = head_i[BYTE_W-1:0];
      RA_DHI:  rdata_o = hold_hi;
      default: rdata_o = '0;
    endcase
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RA_CTRL && reg_wdata == '0) |=> !enable_o); // R3
endmodule

// File: rtl/acq_sample_fifo.sv
`timescale 1ns/1ps
module acq_sample_fifo
  import acq_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [RES_W-1:0]  smp_res,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  logic             enable, flush, iclr, pop, push_req;
  logic             empty, full, half, half_enter, ovf;
  logic [REC_W-1:0] head;
  logic [BYTE_W-1:0] status;

  assign push_req = smp_valid && enable;
  assign status   = status_byte(empty, half, ovf);

  acq_host_regs u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .head_i(head), .status_i(status),
    .enable_o(enable), .flush_o(flush), .iclr_o(iclr), .pop_o(pop),
    .rdata_o(reg_rdata)
  );

  acq_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush_i(flush), .push_i(push_req),
    .rec_i(pack_record(smp_chan, smp_res)), .pop_i(pop), .head_o(head),
    .empty_o(empty), .full_o(full), .half_o(half), .half_enter_o(half_enter)
  );

  acq_fifo_flags u_flags (
    .clk(clk), .rst(rst), .flush_i(flush), .iclr_i(iclr),
    .sample_req_i(push_req), .full_i(full), .half_enter_i(half_enter),
    .ovf_o(ovf), .irq_o(irq)
  );

  AST_IRQ_AT_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> half);                                              // R10
  AST_DISABLED_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (empty && !enable) |=> empty);                                     // R3
  AST_LOW_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_DLO && !empty && !push_req && !flush) |=> !empty); // R5
endmodule

// File: tb/acq_sample_fifo_tb.sv
`timescale 1ns/1ps
module acq_sample_fifo_tb;
  import acq_fifo_pkg::*;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [3:0] smp_chan = '0;
  logic [11:0] smp_res = '0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic irq;

  acq_sample_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_res(smp_res), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] q[$];
  logic m_en = 0, m_ovf = 0, m_irq = 0;
  logic [15:0] m_hold = '0;
  bit m_hold_known = 1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {5'b0, m_ovf, (q.size() >= HALF), (q.size() == 0)};
  endfunction

  task automatic model_update();
    int pre;
    bit hp;
    pre = q.size();
    hp = (pre >= HALF);
    if (reg_rd && reg_addr == 3'd4) begin
      if (pre > 0) begin m_hold = q[0]; m_hold_known = 1; end
      else m_hold_known = 0;
    end
    if (reg_wr && reg_addr == 3'd2) begin
      q.delete();
      m_ovf = 0;
    end else begin
      if (smp_valid && m_en && pre == DEPTH) m_ovf = 1;
      if (reg_rd && reg_addr == 3'd5 && pre > 0) void'(q.pop_front());
      if (smp_valid && m_en && pre < DEPTH) q.push_back({smp_res, smp_chan});
    end
    if (!hp && q.size() >= HALF) m_irq = 1;
    else if (reg_wr && reg_addr == 3'd1) m_irq = 0;
    if (reg_wr && reg_addr == 3'd0) m_en = (reg_wdata != 0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_update();
    chk("R10 irq", {15'b0, irq}, {15'b0, m_irq});
    @(negedge clk);
    smp_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic check_read(input string req);
    bit known;
    logic [7:0] e;
    known = 1;
    case (reg_addr)
      3'd0: e = {7'b0, m_en};
      3'd3: e = exp_status();
      3'd4: begin known = (q.size() > 0); e = known ? q[0][7:0] : 8'h00; end
      3'd5: begin known = m_hold_known; e = m_hold[15:8]; end
      default: e = 8'h00;
    endcase
    if (known) chk(req, {8'b0, reg_rdata}, {8'b0, e});
  endtask

  task automatic do_sample(input logic [3:0] ch, input logic [11:0] res);
    smp_valid = 1; smp_chan = ch; smp_res = res;
    tick();
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    reg_rd = 1; reg_addr = a;
    #1;
    check_read(req);
    tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    reg_addr = 3'd3; #1; chk("R1 status", {8'b0, reg_rdata}, 16'h0001);
    reg_addr = 3'd0; #1; chk("R1 ctrl", {8'b0, reg_rdata}, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);
    @(negedge clk);

    // R3 disabled capture discards
    for (int i = 0; i < 3; i++) do_sample(4'(i), 12'(i * 7 + 1));
    do_read(3'd3, "R3 discard while off");
    do_write(3'd0, 8'h01);
    do_read(3'd0, "R3 ctrl on");

    // R2 R4 R5 ordering and read sequence
    do_sample(4'h3, 12'hABC);
    do_sample(4'h9, 12'h123);
    do_sample(4'hF, 12'h0F0);
    do_read(3'd4, "R2 low byte");
    do_read(3'd4, "R5 low read keeps record");
    do_read(3'd5, "R2 high byte");
    do_read(3'd4, "R4 second record low");
    do_read(3'd5, "R4 second record high");
    do_read(3'd4, "R4 third record low");
    do_read(3'd5, "R4 third record high");
    do_read(3'd3, "R6 empty after drain");
    do_read(3'd5, "R5 high read on empty");
    do_read(3'd3, "R5 empty pop ignored");

    // R7 R10 half-full interrupt
    for (int i = 0; i < HALF; i++) do_sample(4'(i), 12'(i * 33));
    do_read(3'd3, "R7 half bit");
    do_write(3'd1, 8'h00);
    do_read(3'd3, "R10 after clear");

    // R8 overflow
    for (int i = 0; i < HALF + 2; i++) do_sample(4'(i + 5), 12'(i * 91 + 4));
    do_read(3'd3, "R8 overflow set");
    do_read(3'd4, "R8 kept record low");
    do_read(3'd5, "R8 kept record high");
    do_sample(4'h1, 12'h777);
    do_read(3'd3, "R8 overflow sticky");

    // R9 flush with arbitrary value
    do_write(3'd2, 8'h5A);
    do_read(3'd3, "R9 flushed");
    do_read(3'd4, "R9 low after flush");

    // R3 off again
    do_write(3'd0, 8'h00);
    do_sample(4'h2, 12'h222);
    do_read(3'd3, "R3 off discards");
    do_write(3'd0, 8'h80);
    do_read(3'd0, "R3 nonzero enables");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      smp_valid = ($urandom_range(0, 99) < 55);
      smp_chan = 4'($urandom);
      smp_res = 12'($urandom);
      if (r < 2) begin
        reg_wr = 1; reg_addr = 3'd2; reg_wdata = 8'($urandom);
      end else if (r < 5) begin
        reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'($urandom);
      end else if (r < 6) begin
        reg_wr = 1; reg_addr = 3'd0;
        reg_wdata = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
      end else if (r < 50) begin
        reg_rd = 1; reg_addr = 3'($urandom_range(3, 5));
        #1;
        check_read("R2/R4/R5/R6/R7/R8 random read");
      end
      tick();
    end
    do_read(3'd3, "R6 final status");
    finish_up();
  end
endmodule